// File: doc/BRIEF.md
# Pad Attribute Register File

This block stores the electrical attribute word of every pad in a chip's IO ring. There are two independent banks: one holds a word for each multiplexed IO and the other holds a word for each dedicated IO. Each bank drives a packed vector of all its words to the pad logic, and the pad logic applies those attributes directly.

Software reaches the words through a plain single-cycle register bus. A request carries a word offset, a write-enable and write data. Writes take effect on the next clock edge. Reads answer one cycle later with a valid strobe. Every word is write-any-read-legal: bits that have no function are cleared as they are stored. Neither the outputs nor the read path can therefore ever show an illegal encoding.

A two-state response machine sequences the bus side. Its states are `ST_IDLE` (no read answer pending) and `ST_RESP` (read answer on the bus this cycle). The transitions are as follows:
- `IDLE->RESP` happens on a read request.
- `RESP->RESP` happens on a read request in the answer cycle, which gives back-to-back reads.
- `RESP->IDLE` and `IDLE->IDLE` happen when there is no read request.

Top module: `pad_attr_regfile`

## Requirements
- R1: While reset is low and after its asynchronous assertion, every attribute field of both banks is 0, `bus_rvalid` is 0 and `bus_rdata` is 0.
- R2: A write at word offset i, where 0 <= i < N_MIO, sets bits [i*10 +: 10] of `mio_attr_o` at the next clock edge to the legalized write data.
- R3: A write at word offset N_MIO+j, where 0 <= j < N_DIO, sets bits [j*10 +: 10] of `dio_attr_o` at the next clock edge to the legalized write data.
- R4: The attribute word has four legal bits: bit 0 inverts the pad, bit 1 enables open drain, bit 2 enables the pull and bit 3 selects pull direction. Legalizing keeps `bus_wdata[3:0]` and clears every other bit. Bits 9:4 of each field therefore always read 0 and always drive 0, as do `bus_rdata` bits above 3.
- R5: An attribute field changes only in the cycle after a write to its own offset. Writes to other offsets, reads and idle cycles leave it unchanged.
- R6: A read request (`bus_req`=1, `bus_we`=0) causes `bus_rvalid`=1 in the next cycle. No read request causes `bus_rvalid`=0 in the next cycle.
- R7: Read data equals the field held at the moment of the request. After a write, reading the same offset returns exactly the field seen on the attribute output.
- R8: For an offset at or above N_MIO+N_DIO, a read returns 0 and a write changes nothing in either bank.
- R9: Read requests on consecutive cycles each get their own answer, one cycle after each request, with `bus_rvalid` held high throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read answer strobe, one cycle after a read request |
| mio_attr_o | output | N_MIO*10 | Packed muxed-IO attribute fields |
| dio_attr_o | output | N_DIO*10 | Packed dedicated-IO attribute fields |

## Verification
Some properties are checked by assertions on every cycle:
- each reserved field bit is zero;
- no field moves without a write to its own offset in the previous cycle;
- a write lands the legalized value in its entry;
- the read strobe follows read requests exactly;
- out-of-range reads answer zero.

Other behaviours need the bench's scenarios, which keep a model of both banks. These are:
- the offset-to-field mapping across the boundary between the banks;
- read data matching the output field after a write;
- out-of-range writes leaving both whole vectors untouched;
- back-to-back reads returning distinct values in order.

// File: rtl/pad_attr_pkg.sv
package pad_attr_pkg;

    // Legal attribute fields, lowest bit first: invert, open drain, pull enable, pull select
    typedef struct packed {
        logic [5:0] rsvd;
        logic       pull_sel;
        logic       pull_en;
        logic       od_en;
        logic       invert;
    } pad_attr_t;

    localparam int ATTR_W = $bits(pad_attr_t);

    // Only the four functional bits survive a write
    localparam logic [ATTR_W-1:0] LEGAL_MASK = ATTR_W'(4'hF);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } resp_state_e;

endpackage

// File: rtl/pad_attr_bank.sv
module pad_attr_bank
    import pad_attr_pkg::*;
#(
    parameter int N_ENTRY = 8,
    localparam int IW = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IW-1:0]             idx,
    input  logic [ATTR_W-1:0]         wr_data,
    output logic [ATTR_W-1:0]         rd_data,
    output logic [N_ENTRY*ATTR_W-1:0] attr_flat
);

    logic [ATTR_W-1:0] attr_q [N_ENTRY];

    for (genvar e = 0; e < N_ENTRY; e++) begin : g_entry
        logic hit;
        assign hit = wr_en && (idx == IW'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                attr_q[e] <= '0;
            end else if (hit) begin
                attr_q[e] <= wr_data & LEGAL_MASK;
            end
        end

        assign attr_flat[e*ATTR_W +: ATTR_W] = attr_q[e];

        // R4
        rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (attr_q[e] & ~LEGAL_MASK) == '0);

        // R5
        no_stray_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(attr_q[e]) |-> $past(wr_en && (idx == IW'(e))));
    end

    always_comb begin
        rd_data = '0;
        for (int e = 0; e < N_ENTRY; e++) begin
            if (idx == IW'(e)) begin
                rd_data = attr_q[e];
            end
        end
    end

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data_of($past(idx)) == ($past(wr_data) & LEGAL_MASK));

    function automatic logic [ATTR_W-1:0] rd_data_of(input logic [IW-1:0] k);
        logic [ATTR_W-1:0] v;
        v = '0;
        for (int e = 0; e < N_ENTRY; e++) begin
            if (k == IW'(e)) v = attr_q[e];
        end
        return v;
    endfunction

endmodule

// File: rtl/pad_attr_bus_fsm.sv
module pad_attr_bus_fsm
    import pad_attr_pkg::*;
#(
    parameter int N_MIO  = 8,
    parameter int N_DIO  = 6,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int MIO_IW = (N_MIO > 1) ? $clog2(N_MIO) : 1,
    localparam int DIO_IW = (N_DIO > 1) ? $clog2(N_DIO) : 1,
    localparam int N_TOTAL = N_MIO + N_DIO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              mio_wr_en,
    output logic [MIO_IW-1:0] mio_idx,
    output logic              dio_wr_en,
    output logic [DIO_IW-1:0] dio_idx,
    output logic [ATTR_W-1:0] wr_legal,
    input  logic [ATTR_W-1:0] mio_rd,
    input  logic [ATTR_W-1:0] dio_rd
);

    resp_state_e state_q, state_d;
    logic        rd_req;
    logic        in_mio, in_dio;
    logic [ADDR_W-1:0] dio_off;
    logic [DATA_W-1:0] rdata_q, rdata_d;

    function automatic logic [ATTR_W-1:0] legalize(input logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] m;
        m = w & DATA_W'(LEGAL_MASK);
        return m[ATTR_W-1:0];
    endfunction

    assign rd_req  = bus_req && !bus_we;
    assign in_mio  = bus_addr < ADDR_W'(N_MIO);
    assign in_dio  = !in_mio && (bus_addr < ADDR_W'(N_TOTAL));
    assign dio_off = bus_addr - ADDR_W'(N_MIO);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= rdata_d;
        end
    end

    // Next state and read capture
    always_comb begin
        state_d = state_q;
        rdata_d = '0;
        unique case (state_q)
            ST_IDLE: state_d = rd_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (rd_req) begin
            if (in_mio)      rdata_d = DATA_W'(mio_rd);
            else if (in_dio) rdata_d = DATA_W'(dio_rd);
        end
    end

    // Outputs
    always_comb begin
        mio_wr_en  = bus_req && bus_we && in_mio;
        dio_wr_en  = bus_req && bus_we && in_dio;
        mio_idx    = bus_addr[MIO_IW-1:0];
        dio_idx    = dio_off[DIO_IW-1:0];
        wr_legal   = legalize(bus_wdata);
        bus_rvalid = (state_q == ST_RESP);
        bus_rdata  = rdata_q;
    end

    // R6
    rvalid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);

    // R6
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid);

    // R8
    oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (bus_addr >= ADDR_W'(N_TOTAL))) |=> bus_rdata == '0);

    // R8
    oob_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= ADDR_W'(N_TOTAL)) |-> !(mio_wr_en || dio_wr_en));

    // R4
    rdata_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~DATA_W'(LEGAL_MASK)) == '0);

endmodule

// File: rtl/pad_attr_regfile.sv
module pad_attr_regfile
    import pad_attr_pkg::*;
#(
    parameter int N_MIO  = 8,
    parameter int N_DIO  = 6,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int MIO_IW = (N_MIO > 1) ? $clog2(N_MIO) : 1,
    localparam int DIO_IW = (N_DIO > 1) ? $clog2(N_DIO) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_req,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    bus_rvalid,
    output logic [N_MIO*ATTR_W-1:0] mio_attr_o,
    output logic [N_DIO*ATTR_W-1:0] dio_attr_o
);

    logic              mio_wr_en, dio_wr_en;
    logic [MIO_IW-1:0] mio_idx;
    logic [DIO_IW-1:0] dio_idx;
    logic [ATTR_W-1:0] wr_legal, mio_rd, dio_rd;

    pad_attr_bus_fsm #(
        .N_MIO (N_MIO),
        .N_DIO (N_DIO),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rvalid(bus_rvalid),
        .mio_wr_en (mio_wr_en),
        .mio_idx   (mio_idx),
        .dio_wr_en (dio_wr_en),
        .dio_idx   (dio_idx),
        .wr_legal  (wr_legal),
        .mio_rd    (mio_rd),
        .dio_rd    (dio_rd)
    );

    pad_attr_bank #(.N_ENTRY(N_MIO)) u_mio_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mio_wr_en),
        .idx      (mio_idx),
        .wr_data  (wr_legal),
        .rd_data  (mio_rd),
        .attr_flat(mio_attr_o)
    );

    pad_attr_bank #(.N_ENTRY(N_DIO)) u_dio_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (dio_wr_en),
        .idx      (dio_idx),
        .wr_data  (wr_legal),
        .rd_data  (dio_rd),
        .attr_flat(dio_attr_o)
    );

    // R5
    banks_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(($past(mio_wr_en) == 1'b0) && !$stable(mio_attr_o)));

endmodule

// File: tb/pad_attr_regfile_tb.sv
module pad_attr_regfile_tb;

    localparam int N_MIO  = 8;
    localparam int N_DIO  = 6;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int AW     = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_rvalid;
    logic [N_MIO*AW-1:0] mio_attr_o;
    logic [N_DIO*AW-1:0] dio_attr_o;

    logic [AW-1:0] mio_m [N_MIO];
    logic [AW-1:0] dio_m [N_DIO];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pad_attr_regfile #(
        .N_MIO(N_MIO), .N_DIO(N_DIO), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .mio_attr_o(mio_attr_o), .dio_attr_o(dio_attr_o)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [N_MIO*AW-1:0] mio_vec();
        logic [N_MIO*AW-1:0] v;
        for (int i = 0; i < N_MIO; i++) v[i*AW +: AW] = mio_m[i];
        return v;
    endfunction

    function automatic logic [N_DIO*AW-1:0] dio_vec();
        logic [N_DIO*AW-1:0] v;
        for (int i = 0; i < N_DIO; i++) v[i*AW +: AW] = dio_m[i];
        return v;
    endfunction

    task automatic check_banks(input string req);
        check(req, 128'(mio_attr_o), 128'(mio_vec()));
        check(req, 128'(dio_attr_o), 128'(dio_vec()));
    endtask

    task automatic bus_write(input int off, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(off); bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        if (off < N_MIO) mio_m[off] = AW'(d & 32'hF);
        else if (off < N_MIO + N_DIO) dio_m[off - N_MIO] = AW'(d & 32'hF);
    endtask

    task automatic bus_read(input int off, output logic [DATA_W-1:0] d, output logic v);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(off);
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata; v = bus_rvalid;
    endtask

    function automatic logic [DATA_W-1:0] model_rd(input int off);
        if (off < N_MIO) return DATA_W'(mio_m[off]);
        if (off < N_MIO + N_DIO) return DATA_W'(dio_m[off - N_MIO]);
        return '0;
    endfunction

    task automatic t_reset();
        check("R1 rvalid in reset", 128'(bus_rvalid), 128'(0));
        check("R1 rdata in reset", 128'(bus_rdata), 128'(0));
        check_banks("R1 banks in reset");
    endtask

    task automatic t_mio_writes();
        for (int i = 0; i < N_MIO; i++) begin
            bus_write(i, DATA_W'(i + 3));
            check_banks("R2 muxed write");
        end
    endtask

    task automatic t_dio_writes();
        for (int j = 0; j < N_DIO; j++) begin
            bus_write(N_MIO + j, DATA_W'(15 - j));
            check_banks("R3 dedicated write");
        end
    endtask

    task automatic t_reserved();
        bus_write(2, 32'hFFFF_FFFF);
        check("R4 reserved cleared", 128'(mio_attr_o[2*AW +: AW]), 128'(10'h00F));
        bus_write(N_MIO + 1, 32'h0000_03F0);
        check("R4 reserved only", 128'(dio_attr_o[1*AW +: AW]), 128'(0));
        bus_write(5, 32'hABCD_5A5A);
        check("R4 low nibble kept", 128'(mio_attr_o[5*AW +: AW]), 128'(10'h00A));
        check_banks("R4 banks");
    endtask

    task automatic t_isolation();
        logic [N_MIO*AW-1:0] mb;
        logic [N_DIO*AW-1:0] db;
        logic [DATA_W-1:0] d;
        logic v;
        mb = mio_attr_o; db = dio_attr_o;
        bus_read(3, d, v);
        bus_read(N_MIO + 2, d, v);
        repeat (3) @(negedge clk);
        check("R5 reads and idle keep muxed", 128'(mio_attr_o), 128'(mb));
        check("R5 reads and idle keep dedicated", 128'(dio_attr_o), 128'(db));
        bus_write(N_MIO - 1, 32'h6);
        check("R5 boundary muxed write spares dedicated", 128'(dio_attr_o), 128'(db));
        bus_write(N_MIO, 32'h9);
        check_banks("R5 boundary dedicated write");
    endtask

    task automatic t_readback();
        logic [DATA_W-1:0] d;
        logic v;
        for (int k = 0; k < N_MIO + N_DIO; k++) begin
            bus_read(k, d, v);
            check("R6 rvalid after read", 128'(v), 128'(1));
            check("R7 read value", 128'(d), 128'(model_rd(k)));
        end
        @(negedge clk);
        check("R6 rvalid drops", 128'(bus_rvalid), 128'(0));
        bus_write(4, 32'hC);
        bus_read(4, d, v);
        check("R7 read equals output", 128'(d), 128'(mio_attr_o[4*AW +: AW]));
    endtask

    task automatic t_out_of_range();
        logic [DATA_W-1:0] d;
        logic v;
        bus_write(N_MIO + N_DIO, 32'hF);
        bus_write(200, 32'h7);
        check_banks("R8 stray writes ignored");
        bus_read(N_MIO + N_DIO, d, v);
        check("R8 oob read data", 128'(d), 128'(0));
        check("R8 oob read valid", 128'(v), 128'(1));
        bus_read(255, d, v);
        check("R8 top offset read", 128'(d), 128'(0));
    endtask

    task automatic t_back_to_back();
        int offs [4] = '{1, N_MIO + 3, 200, 6};
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0;
        for (int k = 0; k < 4; k++) begin
            bus_addr = ADDR_W'(offs[k]);
            @(negedge clk);
            check("R9 back-to-back rvalid", 128'(bus_rvalid), 128'(1));
            check("R9 back-to-back data", 128'(bus_rdata), 128'(model_rd(offs[k])));
        end
        bus_req = 1'b0;
        @(negedge clk);
        check("R9 rvalid ends", 128'(bus_rvalid), 128'(0));
    endtask

    task automatic t_async_reset();
        #3 rst_n = 1'b0;
        #1;
        for (int i = 0; i < N_MIO; i++) mio_m[i] = '0;
        for (int i = 0; i < N_DIO; i++) dio_m[i] = '0;
        check_banks("R1 async reset clears");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < N_MIO; i++) mio_m[i] = '0;
        for (int i = 0; i < N_DIO; i++) dio_m[i] = '0;
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_mio_writes();
        t_dio_writes();
        t_reserved();
        t_isolation();
        t_readback();
        t_out_of_range();
        t_back_to_back();
        t_async_reset();
        t_readback();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule